// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block manages the receive side of a descriptor-driven packet path. A ring of receive descriptors lives in a small on-chip store. Each descriptor has three 32-bit words: a command word, a high status word and the base address of that descriptor's own packet buffer. Software fills and arms descriptors through a host port. It grants them to hardware by moving a kick position forward. Frames arrive as a byte stream. The engine places each byte of a frame in the buffer named by the current descriptor, then writes back the byte count and an error flag. It clears the ownership bit to hand the descriptor back, steps to the next ring entry and pulses a done strobe that an interrupt block can collect.

When a frame begins and the current descriptor cannot be used, the engine drops the whole frame and counts it as missed. The descriptor cannot be used when it is not armed, or when software has not kicked past it. A frame longer than one buffer is cut at the buffer size and marked as errored. The byte stream uses valid/ready. A byte moves on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` falls for exactly one cycle after the last byte of an accepted frame, the cycle in which the descriptor is written back. It is high at every other time, including while a dropped frame drains. The source may hold or change its byte while `in_ready` is low. The ring depth must be a power of two.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset `ring_pos` is 0, `miss_count` is 0, `rx_done` is 0, `in_ready` is 1, and every descriptor word reads as 0.
- R2: `host_addr[1:0]` selects the word: 0 is the command word, 1 is the high status word, 2 is the buffer base address. The upper bits of `host_addr` select the descriptor. A write lands on the next clock edge. A read strobe returns the word on `host_rdata` after the next clock edge.
- R3: The kick position and the internal ring position are each one bit wider than the ring index. The current descriptor is usable only when bit 31 of its command word is set and the kick position differs from the ring position. Otherwise the descriptor is not usable. This holds even for an armed descriptor.
- R4: Each accepted byte of a taken frame, up to the buffer size, produces exactly one buffer write. The write address is the descriptor's buffer base plus the byte's offset in the frame, and the writes come in arrival order.
- R5: At writeback the command word becomes the frame's byte count, CRC bytes included, placed at bit 16 upward. Bit 31 is cleared and all other bits are 0.
- R6: The high status word is written with bit 30 set when `in_err` accompanied the frame's last byte, and with 0 otherwise.
- R7: A frame longer than the buffer stores only the first buffer-size bytes. Its written count equals the buffer size and bit 30 of the high status word is set.
- R8: A frame whose first byte finds an unusable descriptor is consumed entirely. It causes no buffer write and no writeback, `ring_pos` does not change, and `miss_count` rises by one.
- R9: The ring position advances by one for each written-back frame and wraps from the last descriptor to 0.
- R10: `rx_done` is a one-cycle pulse. It is high in the second cycle after the edge that took the last byte, and the written-back descriptor is readable from that cycle on.
- R11: `in_ready` is low for exactly the one cycle after the last byte of a taken frame. It stays high while a dropped frame drains.
- R12: A `soft_rst` cycle returns the ring position, the kick position and `miss_count` to 0 and abandons any frame in progress without writeback. Descriptor contents are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous ring restart |
| host_wr | input | 1 | Descriptor word write strobe |
| host_rd | input | 1 | Descriptor word read strobe |
| host_addr | input | IDX_W+2 | Descriptor index and word select |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered |
| kick_wr | input | 1 | Kick position write strobe |
| kick_val | input | IDX_W+1 | New kick position |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted when high |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last byte of frame |
| in_err | input | 1 | Frame error, sampled with the last byte |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| rx_done | output | 1 | Writeback done pulse |
| ring_pos | output | IDX_W | Current ring index |
| miss_count | output | MISS_W | Dropped frame count |

## Verification
The bench builds the engine with a four-entry ring and 16-byte buffers. A sweep of frame lengths from 1 to 20 bytes therefore crosses the exact buffer fit and the truncation boundary, and wraps the ring five times. With the small ring, the kick window can also be exhausted after only a few frames. This brings the no-grant drop, the disarmed-but-granted drop and a soft restart in the middle of a frame within reach of a short run. Each expected byte, count and status word is derived arithmetically from the frame number and length.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W  = 32;
  localparam int OWN_BIT = 31;
  localparam int ERR_BIT = 30;
  localparam int LEN_LSB = 16;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BUF  = 2'd2,
    SEL_NONE = 2'd3
  } word_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_DROP,
    ST_WB
  } rx_state_e;
endpackage

// File: rtl/rxr_desc_store.sv
module rxr_desc_store
  import rxr_pkg::*;
#(
  parameter int NUM_DESC = 32,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [IDX_W-1:0]  host_idx,
  input  word_sel_e         host_sel,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic              cur_own,
  output logic [WORD_W-1:0] cur_base,
  input  logic              eng_we,
  input  logic [WORD_W-1:0] eng_cmd,
  input  logic [WORD_W-1:0] eng_stat
);
  logic [WORD_W-1:0] cmd_v  [NUM_DESC];
  logic [WORD_W-1:0] stat_v [NUM_DESC];
  logic [WORD_W-1:0] base_v [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
    logic [WORD_W-1:0] cmd_q, stat_q, base_q;
    logic hit_eng, hit_host;
    assign hit_eng  = eng_we  && (cur_idx  == IDX_W'(g));
    assign hit_host = host_wr && (host_idx == IDX_W'(g));

    // Hardware writeback wins over a host write to the same word.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_q  <= '0;
        stat_q <= '0;
        base_q <= '0;
      end else begin
        if (hit_eng)                              cmd_q  <= eng_cmd;
        else if (hit_host && host_sel == SEL_CMD)  cmd_q  <= host_wdata;
        if (hit_eng)                              stat_q <= eng_stat;
        else if (hit_host && host_sel == SEL_STAT) stat_q <= host_wdata;
        if (hit_host && host_sel == SEL_BUF)       base_q <= host_wdata;
      end
    end

    assign cmd_v[g]  = cmd_q;
    assign stat_v[g] = stat_q;
    assign base_v[g] = base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      case (host_sel)
        SEL_CMD:  host_rdata <= cmd_v[host_idx];
        SEL_STAT: host_rdata <= stat_v[host_idx];
        SEL_BUF:  host_rdata <= base_v[host_idx];
        default:  host_rdata <= '0;
      endcase
    end
  end

  assign cur_own  = cmd_v[cur_idx][OWN_BIT];
  assign cur_base = base_v[cur_idx];

  // R5: a written-back descriptor no longer belongs to hardware.
  p_hand_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |=> !cmd_v[$past(cur_idx)][OWN_BIT]);
endmodule

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl #(
  parameter int NUM_DESC = 32,
  localparam int IDX_W = $clog2(NUM_DESC),
  localparam int POS_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             kick_wr,
  input  logic [POS_W-1:0] kick_val,
  input  logic             advance,
  output logic [IDX_W-1:0] cur_idx,
  output logic             granted
);
  logic [POS_W-1:0] pos_q, kick_q, room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      kick_q <= '0;
    end else if (soft_rst) begin
      pos_q  <= '0;
      kick_q <= '0;
    end else begin
      if (kick_wr) kick_q <= kick_val;
      if (advance) pos_q  <= pos_q + POS_W'(1);
    end
  end

  assign room    = kick_q - pos_q;
  assign granted = (room != '0);
  assign cur_idx = pos_q[IDX_W-1:0];

  p_pos_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(soft_rst) && pos_q != $past(pos_q)) |-> pos_q == $past(pos_q) + POS_W'(1));

  p_soft_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (pos_q == '0 && !granted));
endmodule

// File: rtl/rxr_frame_fsm.sv
module rxr_frame_fsm
  import rxr_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int MISS_W = 16,
  localparam int LEN_W = $clog2(BUF_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              in_ready,
  input  logic              desc_usable,
  input  logic [WORD_W-1:0] desc_base,
  output logic              buf_we,
  output logic [WORD_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              eng_we,
  output logic [WORD_W-1:0] eng_cmd,
  output logic [WORD_W-1:0] eng_stat,
  output logic              rx_done,
  output logic [MISS_W-1:0] miss_count
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(BUF_BYTES);

  rx_state_e         state_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              ovf_q, err_q;
  logic [WORD_W-1:0] base_q;
  logic              beat;

  assign in_ready = (state_q != ST_WB);
  assign beat     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      ovf_q      <= 1'b0;
      err_q      <= 1'b0;
      base_q     <= '0;
      buf_we     <= 1'b0;
      buf_addr   <= '0;
      buf_wdata  <= '0;
      rx_done    <= 1'b0;
      miss_count <= '0;
    end else if (soft_rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      ovf_q      <= 1'b0;
      err_q      <= 1'b0;
      buf_we     <= 1'b0;
      rx_done    <= 1'b0;
      miss_count <= '0;
    end else begin
      buf_we  <= 1'b0;
      rx_done <= (state_q == ST_WB);
      case (state_q)
        ST_IDLE: if (beat) begin
          if (desc_usable) begin
            base_q    <= desc_base;
            buf_we    <= 1'b1;
            buf_addr  <= desc_base;
            buf_wdata <= in_data;
            cnt_q     <= LEN_W'(1);
            ovf_q     <= 1'b0;
            err_q     <= in_err;
            state_q   <= in_last ? ST_WB : ST_RECV;
          end else begin
            miss_count <= miss_count + MISS_W'(1);
            state_q    <= in_last ? ST_IDLE : ST_DROP;
          end
        end
        ST_RECV: if (beat) begin
          if (cnt_q < LEN_CAP) begin
            buf_we    <= 1'b1;
            buf_addr  <= base_q + WORD_W'(cnt_q);
            buf_wdata <= in_data;
            cnt_q     <= cnt_q + LEN_W'(1);
          end else begin
            ovf_q <= 1'b1;
          end
          if (in_last) begin
            err_q   <= in_err;
            state_q <= ST_WB;
          end
        end
        ST_DROP: if (beat && in_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    eng_we   = (state_q == ST_WB) && !soft_rst;
    eng_cmd  = '0;
    eng_cmd[LEN_LSB +: LEN_W] = cnt_q;
    eng_stat = '0;
    eng_stat[ERR_BIT] = err_q || ovf_q;
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |-> !buf_we);

  p_miss_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(soft_rst) && miss_count != $past(miss_count))
      |-> miss_count == $past(miss_count) + MISS_W'(1));

  p_ready_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECV && beat && in_last && !soft_rst) |=> !in_ready ##1 in_ready);
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
  import rxr_pkg::*;
#(
  parameter int NUM_DESC = 32,
  parameter int BUF_BYTES = 2048,
  parameter int MISS_W = 16,
  localparam int IDX_W = $clog2(NUM_DESC),
  localparam int POS_W = IDX_W + 1,
  localparam int HADDR_W = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               kick_wr,
  input  logic [POS_W-1:0]   kick_val,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  input  logic               in_err,
  output logic               buf_we,
  output logic [31:0]        buf_addr,
  output logic [7:0]         buf_wdata,
  output logic               rx_done,
  output logic [IDX_W-1:0]   ring_pos,
  output logic [MISS_W-1:0]  miss_count
);
  logic              cur_own, granted, eng_we;
  logic [WORD_W-1:0] cur_base, eng_cmd, eng_stat;
  logic [IDX_W-1:0]  cur_idx;

  rxr_ring_ctrl #(.NUM_DESC(NUM_DESC)) u_ring (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .kick_wr(kick_wr), .kick_val(kick_val), .advance(eng_we),
    .cur_idx(cur_idx), .granted(granted)
  );

  rxr_desc_store #(.NUM_DESC(NUM_DESC)) u_store (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd),
    .host_idx(host_addr[HADDR_W-1:2]), .host_sel(word_sel_e'(host_addr[1:0])),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cur_idx(cur_idx), .cur_own(cur_own), .cur_base(cur_base),
    .eng_we(eng_we), .eng_cmd(eng_cmd), .eng_stat(eng_stat)
  );

  rxr_frame_fsm #(.BUF_BYTES(BUF_BYTES), .MISS_W(MISS_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .in_ready(in_ready), .desc_usable(cur_own && granted), .desc_base(cur_base),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .eng_we(eng_we), .eng_cmd(eng_cmd), .eng_stat(eng_stat),
    .rx_done(rx_done), .miss_count(miss_count)
  );

  assign ring_pos = cur_idx;
endmodule

// File: tb/sim_rxr_ring_engine.sv
module sim_rxr_ring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;
  localparam int BB = 16;
  localparam int IW = 2;
  localparam int PW = 3;
  localparam int HW = 4;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam int BASE = 'h100;

  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic host_wr = 0, host_rd = 0, kick_wr = 0;
  logic [HW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic [PW-1:0] kick_val = '0;
  logic in_valid = 0, in_last = 0, in_err = 0, in_ready;
  logic [7:0] in_data = '0;
  logic buf_we, rx_done;
  logic [31:0] buf_addr;
  logic [7:0] buf_wdata;
  logic [IW-1:0] ring_pos;
  logic [15:0] miss_count;

  int total = 0, bad = 0, wr_cnt = 0, done_cnt = 0, fno = 0, kickv = 0, exp_pos = 0;
  logic prev_done = 0;
  logic [7:0] shadow [0:ND*BB-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxr_ring_engine #(.NUM_DESC(ND), .BUF_BYTES(BB), .MISS_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .kick_wr(kick_wr), .kick_val(kick_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_err(in_err),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .rx_done(rx_done), .ring_pos(ring_pos), .miss_count(miss_count)
  );

  always @(negedge clk) begin
    if (buf_we) begin
      wr_cnt++;
      if (buf_addr >= BASE && buf_addr < BASE + ND*BB) shadow[buf_addr - BASE] = buf_wdata;
    end
    if (rx_done) begin
      done_cnt++;
      if (prev_done) begin total++; bad++; $display("FAIL R10 rx_done wider than one cycle act=1 exp=0"); end
    end
    prev_done = rx_done;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int k);
    return 8'((f * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic hwrite(input int idx, input int sel, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = HW'(idx * 4 + sel); host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(input int idx, input int sel, output logic [31:0] v);
    @(negedge clk); host_rd = 1; host_addr = HW'(idx * 4 + sel);
    @(negedge clk); host_rd = 0; v = host_rdata;
  endtask

  task automatic kick(input int v);
    @(negedge clk); kick_wr = 1; kick_val = PW'(v);
    @(negedge clk); kick_wr = 0;
  endtask

  task automatic beat(input logic [7:0] d, input logic l, input logic e);
    @(negedge clk); in_valid = 1; in_data = d; in_last = l; in_err = e;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 0; in_last = 0; in_err = 0;
  endtask

  task automatic send(input int len, input logic err, output logic rdy_after);
    for (int k = 0; k < len; k++) beat(pat(fno, k), k == len - 1, err && (k == len - 1));
    rdy_after = in_ready;
  endtask

  task automatic take_frame(input int len, input logic err);
    int w0, d0, idx, stored;
    logic r;
    logic [31:0] v;
    logic ok;
    w0 = wr_cnt; d0 = done_cnt; idx = exp_pos;
    stored = (len > BB) ? BB : len;
    send(len, err, r);
    chk("R11 ready low in writeback cycle", {31'b0, r}, 32'd0);
    @(negedge clk);
    chk("R10 done pulse timing", {31'b0, rx_done}, 32'd1);
    chk("R11 ready back after writeback", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
    chk("R4 R7 buffer write count", 32'(wr_cnt - w0), 32'(stored));
    chk("R10 one done per frame", 32'(done_cnt - d0), 32'd1);
    exp_pos = (exp_pos + 1) % ND;
    chk("R9 ring position step and wrap", 32'(ring_pos), 32'(exp_pos));
    hread(idx, 0, v);
    chk("R5 R7 command writeback", v, 32'(stored) << 16);
    hread(idx, 1, v);
    chk("R6 R7 status writeback", v, (err || len > BB) ? 32'h4000_0000 : 32'd0);
    ok = 1;
    for (int k = 0; k < stored; k++) if (shadow[idx * BB + k] !== pat(fno, k)) ok = 0;
    chk("R4 buffer contents", {31'b0, ok}, 32'd1);
    fno++;
  endtask

  task automatic drop_frame(input int len);
    int w0, d0, m0, p0;
    logic r;
    w0 = wr_cnt; d0 = done_cnt; m0 = int'(miss_count); p0 = int'(ring_pos);
    send(len, 1'b0, r);
    chk("R11 ready stays high on drop", {31'b0, r}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R8 no buffer writes on drop", 32'(wr_cnt - w0), 32'd0);
    chk("R8 no done on drop", 32'(done_cnt - d0), 32'd0);
    chk("R8 miss count step", 32'(miss_count), 32'(m0 + 1));
    chk("R8 position held on drop", 32'(ring_pos), 32'(p0));
    fno++;
  endtask

  task automatic rearm(input int idx);
    hwrite(idx, 1, 32'd0);
    hwrite(idx, 0, OWN);
    kickv = (kickv + 1) % (2 * ND);
    kick(kickv);
  endtask

  initial begin
    logic [31:0] v;
    logic r;
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ring_pos reset", 32'(ring_pos), 32'd0);
    chk("R1 miss reset", 32'(miss_count), 32'd0);
    chk("R1 done reset", {31'b0, rx_done}, 32'd0);
    chk("R1 ready reset", {31'b0, in_ready}, 32'd1);
    for (int i = 0; i < ND; i++) for (int s = 0; s < 3; s++) begin
      hread(i, s, v);
      chk("R1 descriptor word reset", v, 32'd0);
    end

    for (int i = 0; i < ND; i++) begin
      hwrite(i, 2, 32'(BASE + i * BB));
      hwrite(i, 0, OWN);
    end
    hread(2, 2, v);
    chk("R2 buffer word readback", v, 32'(BASE + 2 * BB));
    hread(3, 0, v);
    chk("R2 command word readback", v, OWN);
    hread(1, 1, v);
    chk("R2 status word readback", v, 32'd0);

    // R3: armed but not yet kicked -> dropped
    drop_frame(2);

    kickv = ND;
    kick(kickv);
    for (int len = 1; len <= BB + 4; len++) begin
      take_frame(len, (len % 5) == 0);
      rearm((exp_pos + ND - 1) % ND);
    end

    // exhaust the granted window
    for (int n = 0; n < ND; n++) take_frame(3, 1'b0);
    drop_frame(3);  // R3 window empty

    // R3: granted but disarmed
    kickv = (kickv + 1) % (2 * ND);
    kick(kickv);
    drop_frame(4);
    hwrite(exp_pos, 0, OWN);
    take_frame(5, 1'b0);

    // R12: soft reset mid-frame
    hwrite(exp_pos, 0, OWN);
    kickv = (kickv + 1) % (2 * ND);
    kick(kickv);
    d0 = done_cnt;
    beat(8'h11, 1'b0, 1'b0);
    beat(8'h22, 1'b0, 1'b0);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    repeat (2) @(negedge clk);
    chk("R12 position cleared", 32'(ring_pos), 32'd0);
    chk("R12 miss cleared", 32'(miss_count), 32'd0);
    chk("R12 no writeback", 32'(done_cnt - d0), 32'd0);
    hread(1, 0, v);
    chk("R12 descriptor kept", v, OWN);
    exp_pos = 0; kickv = 0;
    drop_frame(2);  // kick cleared as well
    hwrite(0, 0, OWN);
    kickv = 1;
    kick(kickv);
    take_frame(6, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule